// File: doc/BRIEF.md
# Change-of-Signaling Capture Buffer

This block sits on the receive side of a 24-channel T1 path and watches the robbed-bit signaling carried in the least significant bit of each channel byte. Channel bytes arrive one per valid strobe, and a start marker flags the first byte of a multiframe. The block counts channels and frames from that marker and builds a 4-bit A/B/C/D code for every channel. In 24-frame extended-superframe (ESF) mode the bits come from frames 6, 12, 18 and 24. In 12-frame superframe (SF) mode only A and B exist, and they are repeated as C and D.

For each channel the block keeps a flag that is set whenever a newly completed code differs from the code already held. The host sees each code in two banks. The immediate bank changes at the moment the code completes. The delayed bank receives the value the immediate bank held just before that update, so a new code reaches it one full multiframe later. A host that keeps its own last-known code therefore reads the immediate bank first. If that value differs from its saved code, it is the new code; otherwise the delayed bank holds it. A host read of a flag byte clears the eight flags in that byte.

Top module: `cas_capture_buffer`

## Requirements
- R1: Bytes are taken only when `byte_valid` is high. The first byte marked by `mf_start` is channel index 0 of frame index 0, and each later taken byte advances the channel, then the frame, wrapping after 24 frames (ESF) or 12 frames (SF).
- R2: In ESF mode (`esf_mode`=1), bit 0 of a channel's byte in frames 6, 12, 18 and 24 (1-based) becomes code bits 3, 2, 1 and 0. Bit 0 in every other frame has no effect.
- R3: In SF mode (`esf_mode`=0), bit 0 in frames 6 and 12 gives A and B, and the stored code is {A,B,A,B}.
- R4: The immediate bank at addresses 0x01..0x18 (channels 1..24) returns the code in bits 3:0 and zero in bits 7:4. It updates at the channel's last signaling byte.
- R5: The delayed bank at addresses 0x21..0x38 takes, at each completion, the value the immediate bank held just before it, so a new code appears there one multiframe later.
- R6: A channel's flag is set when its completed code differs from the held immediate code. Flags read at 0x40, 0x41 and 0x42, with bit i of byte g standing for channel 8g+i+1.
- R7: A read of a flag byte clears those eight flags. A flag set in the same cycle as that read stays set.
- R8: Reset clears all codes, both banks and all flags. Completions before the end of the first full multiframe after reset load codes without setting any flag.
- R9: A change of `esf_mode` drops frame alignment. All bytes are ignored until the next `mf_start`.
- R10: `rd_data` is registered and returns the addressed value one cycle after `rd_en`. Unmapped addresses return 0, and `rd_data` holds its value while `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| esf_mode | input | 1 | 1 selects 24-frame ESF, 0 selects 12-frame SF |
| byte_valid | input | 1 | Channel byte strobe |
| byte_data | input | 8 | Channel byte; bit 0 carries signaling |
| mf_start | input | 1 | Marks the first byte of a multiframe |
| rd_en | input | 1 | Host read strobe |
| rd_addr | input | 8 | Host read address |
| rd_data | output | 8 | Registered host read data |

## Verification
Two functions can meet in one cycle: a channel's flag being set by a changed code, and the host read that clears the flag byte holding that channel. The bench provokes this by issuing the flag-byte read on exactly the byte that completes a changed channel. It then expects the returned byte to show the flags as they stood before the edge. A later read must still show that channel's flag, while the other channels of the byte read cleared. Every value is predicted by a reference model that the bench steps edge by edge from the requirements.

// File: rtl/cas_pkg.sv
// Shared constants for the change-of-signaling capture buffer.
// Assumes a T1 frame of 24 channel bytes and signaling every sixth frame.
package cas_pkg;
    localparam int ESF_FRAMES = 24;   // frames per extended superframe
    localparam int SF_FRAMES  = 12;   // frames per superframe
    localparam int SIG_EVERY  = 6;    // signaling frame spacing
    localparam int CODE_W     = 4;    // A,B,C,D
    localparam int FRM_W      = $clog2(ESF_FRAMES);
    localparam int ADDR_W     = 8;
    localparam int DATA_W     = 8;
    localparam int IMM_BASE   = 8'h01;
    localparam int DLY_BASE   = 8'h21;
    localparam int FLAG_BASE  = 8'h40;
endpackage

// File: rtl/cas_frame_pos.sv
// Tracks channel and frame position from the multiframe start marker.
// Assumes mf_start only matters together with byte_valid; a mode change
// drops alignment until the next marker.
module cas_frame_pos
    import cas_pkg::*;
#(
    parameter int NUM_CH = 24,
    localparam int CH_W  = $clog2(NUM_CH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            esf_mode,
    input  logic            byte_valid,
    input  logic            mf_start,
    output logic            pos_strobe,
    output logic [CH_W-1:0] pos_ch,
    output logic [1:0]      pos_slot,
    output logic            pos_is_sig,
    output logic            pos_last_slot
);
    localparam logic [FRM_W-1:0] SIG_PERIOD = FRM_W'(SIG_EVERY);
    localparam logic [CH_W-1:0]  LAST_CH    = CH_W'(NUM_CH - 1);

    logic [CH_W-1:0]  ch_q;
    logic [FRM_W-1:0] frm_q;
    logic             locked_q;
    logic             mode_q;
    logic             mode_chg;
    logic [FRM_W-1:0] cur_frm;
    logic [FRM_W-1:0] frm_last;
    logic [FRM_W-1:0] slot_full;

    // Decode the position of the byte presented this cycle.
    always_comb begin
        mode_chg      = (esf_mode != mode_q);
        pos_strobe    = byte_valid && (mf_start || (locked_q && !mode_chg));
        pos_ch        = mf_start ? '0 : ch_q;
        cur_frm       = mf_start ? '0 : frm_q;
        frm_last      = esf_mode ? FRM_W'(ESF_FRAMES - 1) : FRM_W'(SF_FRAMES - 1);
        pos_is_sig    = ((cur_frm % SIG_PERIOD) == SIG_PERIOD - 1'b1);
        slot_full     = cur_frm / SIG_PERIOD;
        pos_slot      = slot_full[1:0];
        pos_last_slot = (pos_slot == (esf_mode ? 2'd3 : 2'd1));
    end

    // Advance the channel/frame counters and keep the lock state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ch_q     <= '0;
            frm_q    <= '0;
            locked_q <= 1'b0;
            mode_q   <= esf_mode;
        end else begin
            mode_q <= esf_mode;
            if (pos_strobe) begin
                if (pos_ch == LAST_CH) begin
                    ch_q  <= '0;
                    frm_q <= (cur_frm == frm_last) ? '0 : cur_frm + 1'b1;
                end else begin
                    ch_q  <= pos_ch + 1'b1;
                    frm_q <= cur_frm;
                end
            end
            if (pos_strobe && mf_start)
                locked_q <= 1'b1;
            else if (mode_chg)
                locked_q <= 1'b0;
        end
    end
endmodule

// File: rtl/cas_sig_store.sv
// Collects signaling bits per channel, forms the code at the last
// signaling frame, keeps the immediate and delayed banks and change flags.
// Assumes pos_ch never exceeds NUM_CH-1 (guaranteed by cas_frame_pos).
module cas_sig_store
    import cas_pkg::*;
#(
    parameter int NUM_CH = 24,
    localparam int CH_W  = $clog2(NUM_CH)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     esf_mode,
    input  logic                     pos_strobe,
    input  logic [CH_W-1:0]          pos_ch,
    input  logic [1:0]               pos_slot,
    input  logic                     pos_is_sig,
    input  logic                     pos_last_slot,
    input  logic                     sig_bit,
    input  logic [NUM_CH-1:0]        flag_clr,
    output logic [NUM_CH*CODE_W-1:0] imm_flat,
    output logic [NUM_CH*CODE_W-1:0] dly_flat,
    output logic [NUM_CH-1:0]        flags,
    output logic [NUM_CH-1:0]        flag_set,
    output logic                     primed,
    output logic                     cmp_valid,
    output logic [CH_W-1:0]          cmp_ch,
    output logic [CODE_W-1:0]        cmp_code
);
    logic [CODE_W-1:0] acc_q [NUM_CH];
    logic [CODE_W-1:0] imm_q [NUM_CH];
    logic [CODE_W-1:0] dly_q [NUM_CH];
    logic [CODE_W-1:0] acc_cur;
    logic              code_differs;

    // Form the completed code from the held bits and the current bit.
    always_comb begin
        acc_cur      = acc_q[pos_ch];
        cmp_valid    = pos_strobe && pos_is_sig && pos_last_slot;
        cmp_ch       = pos_ch;
        cmp_code     = esf_mode ? {acc_cur[3], acc_cur[2], acc_cur[1], sig_bit}
                                : {acc_cur[3], sig_bit, acc_cur[3], sig_bit};
        code_differs = (cmp_code != imm_q[pos_ch]);
    end

    // Arm flagging once the first full multiframe has completed.
    always_ff @(posedge clk) begin
        if (!rst_n)
            primed <= 1'b0;
        else if (cmp_valid && pos_ch == CH_W'(NUM_CH - 1))
            primed <= 1'b1;
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
        logic hit;
        logic flag_q;
        assign hit         = pos_strobe && (pos_ch == CH_W'(g));
        assign flag_set[g] = hit && cmp_valid && primed && code_differs;

        // Hold signaling bits of the current multiframe for this channel.
        always_ff @(posedge clk) begin
            if (!rst_n)
                acc_q[g] <= '0;
            else if (hit && pos_is_sig && !pos_last_slot)
                acc_q[g][3 - pos_slot] <= sig_bit;
        end

        // Move the old immediate code to the delayed bank, load the new one.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                imm_q[g] <= '0;
                dly_q[g] <= '0;
            end else if (hit && cmp_valid) begin
                dly_q[g] <= imm_q[g];
                imm_q[g] <= cmp_code;
            end
        end

        // Change flag: a new set wins over a host clear.
        always_ff @(posedge clk) begin
            if (!rst_n)
                flag_q <= 1'b0;
            else
                flag_q <= flag_set[g] | (flag_q & ~flag_clr[g]);
        end

        assign flags[g]                       = flag_q;
        assign imm_flat[g*CODE_W +: CODE_W]   = imm_q[g];
        assign dly_flat[g*CODE_W +: CODE_W]   = dly_q[g];
    end
endmodule

// File: rtl/cas_host_port.sv
// Registered host read port: decodes the address onto the two code banks
// and the packed flag bytes, and issues flag clears for flag-byte reads.
// Assumes all mapped ranges fit in the 8-bit address space.
module cas_host_port
    import cas_pkg::*;
#(
    parameter int NUM_CH    = 24,
    localparam int FLAG_BYT = (NUM_CH + 7) / 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     rd_en,
    input  logic [ADDR_W-1:0]        rd_addr,
    input  logic [NUM_CH*CODE_W-1:0] imm_flat,
    input  logic [NUM_CH*CODE_W-1:0] dly_flat,
    input  logic [NUM_CH-1:0]        flags,
    output logic [NUM_CH-1:0]        flag_clr,
    output logic [DATA_W-1:0]        rd_data
);
    logic [FLAG_BYT*8-1:0] flags_pad;
    logic [FLAG_BYT-1:0]   grp_hit;
    logic [DATA_W-1:0]     sel;

    assign flags_pad = {{(FLAG_BYT*8-NUM_CH){1'b0}}, flags};

    // Select which flag byte, if any, the current read addresses.
    for (genvar b = 0; b < FLAG_BYT; b++) begin : g_grp
        assign grp_hit[b] = rd_en && (rd_addr == ADDR_W'(FLAG_BASE + b));
    end

    // Spread each byte hit onto the flags it covers.
    for (genvar c = 0; c < NUM_CH; c++) begin : g_clr
        assign flag_clr[c] = grp_hit[c / 8];
    end

    // Address decode onto banks and flag bytes; unmapped reads give zero.
    always_comb begin
        sel = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (rd_addr == ADDR_W'(IMM_BASE + i))
                sel = {{(DATA_W-CODE_W){1'b0}}, imm_flat[i*CODE_W +: CODE_W]};
            if (rd_addr == ADDR_W'(DLY_BASE + i))
                sel = {{(DATA_W-CODE_W){1'b0}}, dly_flat[i*CODE_W +: CODE_W]};
        end
        for (int b = 0; b < FLAG_BYT; b++) begin
            if (rd_addr == ADDR_W'(FLAG_BASE + b))
                sel = flags_pad[b*8 +: 8];
        end
    end

    // Register the read result on each strobe; hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_data <= '0;
        else if (rd_en)
            rd_data <= sel;
    end
endmodule

// File: rtl/cas_capture_buffer.sv
// Top of the change-of-signaling capture buffer: position tracking,
// code capture with two banks and flags, and the host read port.
// Assumes one channel byte per byte_valid strobe, in channel order.
module cas_capture_buffer
    import cas_pkg::*;
#(
    parameter int NUM_CH = 24,
    localparam int CH_W  = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              esf_mode,
    input  logic              byte_valid,
    input  logic [7:0]        byte_data,
    input  logic              mf_start,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    logic                     pos_strobe;
    logic [CH_W-1:0]          pos_ch;
    logic [1:0]               pos_slot;
    logic                     pos_is_sig;
    logic                     pos_last_slot;
    logic [NUM_CH*CODE_W-1:0] imm_flat;
    logic [NUM_CH*CODE_W-1:0] dly_flat;
    logic [NUM_CH-1:0]        flags;
    logic [NUM_CH-1:0]        flag_set;
    logic [NUM_CH-1:0]        flag_clr;
    logic                     primed;
    logic                     cmp_valid;
    logic [CH_W-1:0]          cmp_ch;
    logic [CODE_W-1:0]        cmp_code;
    logic                     unused_payload;

    assign unused_payload = ^byte_data[7:1];

    cas_frame_pos #(.NUM_CH(NUM_CH)) u_pos (
        .clk(clk), .rst_n(rst_n), .esf_mode(esf_mode),
        .byte_valid(byte_valid), .mf_start(mf_start),
        .pos_strobe(pos_strobe), .pos_ch(pos_ch), .pos_slot(pos_slot),
        .pos_is_sig(pos_is_sig), .pos_last_slot(pos_last_slot)
    );

    cas_sig_store #(.NUM_CH(NUM_CH)) u_store (
        .clk(clk), .rst_n(rst_n), .esf_mode(esf_mode),
        .pos_strobe(pos_strobe), .pos_ch(pos_ch), .pos_slot(pos_slot),
        .pos_is_sig(pos_is_sig), .pos_last_slot(pos_last_slot),
        .sig_bit(byte_data[0]), .flag_clr(flag_clr),
        .imm_flat(imm_flat), .dly_flat(dly_flat), .flags(flags),
        .flag_set(flag_set), .primed(primed), .cmp_valid(cmp_valid),
        .cmp_ch(cmp_ch), .cmp_code(cmp_code)
    );

    cas_host_port #(.NUM_CH(NUM_CH)) u_host (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr),
        .imm_flat(imm_flat), .dly_flat(dly_flat), .flags(flags),
        .flag_clr(flag_clr), .rd_data(rd_data)
    );
endmodule

// File: rtl/cas_capture_checker.sv
// Property checker for cas_capture_buffer, attached by bind below.
// Assumes the internal signal names of the top module.
module cas_capture_checker
    import cas_pkg::*;
#(
    parameter int NUM_CH = 24,
    localparam int CH_W  = $clog2(NUM_CH)
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     esf_mode,
    input logic                     mf_start,
    input logic                     rd_en,
    input logic [ADDR_W-1:0]        rd_addr,
    input logic [DATA_W-1:0]        rd_data,
    input logic                     pos_strobe,
    input logic [NUM_CH*CODE_W-1:0] imm_flat,
    input logic [NUM_CH*CODE_W-1:0] dly_flat,
    input logic [NUM_CH-1:0]        flags,
    input logic [NUM_CH-1:0]        flag_set,
    input logic                     primed,
    input logic                     cmp_valid,
    input logic [CH_W-1:0]          cmp_ch,
    input logic [CODE_W-1:0]        cmp_code
);
    logic              seen_v;
    logic [CH_W-1:0]   seen_ch;
    logic [CODE_W-1:0] seen_code;
    logic [CODE_W-1:0] seen_old;

    // Remember the last completion so the next cycle can be judged.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_v    <= 1'b0;
            seen_ch   <= '0;
            seen_code <= '0;
            seen_old  <= '0;
        end else begin
            seen_v    <= cmp_valid;
            seen_ch   <= cmp_ch;
            seen_code <= cmp_code;
            seen_old  <= imm_flat[int'(cmp_ch)*CODE_W +: CODE_W];
        end
    end

    a_r4_code_high_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_addr < ADDR_W'(FLAG_BASE)) |=> (rd_data[7:4] == 4'b0));

    a_r4_imm_loads_code: assert property (@(posedge clk) disable iff (!rst_n)
        seen_v |-> (imm_flat[int'(seen_ch)*CODE_W +: CODE_W] == seen_code));

    a_r5_dly_takes_old: assert property (@(posedge clk) disable iff (!rst_n)
        seen_v |-> (dly_flat[int'(seen_ch)*CODE_W +: CODE_W] == seen_old));

    a_r7_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_set != '0) |=> ((flags & $past(flag_set)) == $past(flag_set)));

    a_r8_quiet_before_primed: assert property (@(posedge clk) disable iff (!rst_n)
        !primed |-> (flags == '0));

    a_r9_mode_change_unlocks: assert property (@(posedge clk) disable iff (!rst_n)
        ((esf_mode != $past(esf_mode)) && !mf_start) |-> !pos_strobe);

    a_r10_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));
endmodule

bind cas_capture_buffer cas_capture_checker #(.NUM_CH(NUM_CH)) u_chk (
    .clk(clk), .rst_n(rst_n), .esf_mode(esf_mode), .mf_start(mf_start),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .pos_strobe(pos_strobe), .imm_flat(imm_flat), .dly_flat(dly_flat),
    .flags(flags), .flag_set(flag_set), .primed(primed),
    .cmp_valid(cmp_valid), .cmp_ch(cmp_ch), .cmp_code(cmp_code)
);

// File: tb/sim_cas_capture_buffer.sv
// Self-checking bench: a reference model stepped edge by edge from the
// requirements predicts every host read.
module sim_cas_capture_buffer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       esf_mode = 1'b1;
    logic       byte_valid = 1'b0;
    logic [7:0] byte_data = 8'h00;
    logic       mf_start = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] rd_addr = 8'h00;
    logic [7:0] rd_data;

    int total = 0;
    int bad = 0;

    // Reference model state
    logic [3:0] m_imm [24];
    logic [3:0] m_dly [24];
    logic [3:0] m_acc [24];
    logic       m_flag [24];
    logic       m_primed, m_locked, m_mode_q;
    int         m_ch, m_frm;

    always #4 clk = ~clk;   // 125 MHz

    cas_capture_buffer u0 (
        .clk(clk), .rst_n(rst_n), .esf_mode(esf_mode),
        .byte_valid(byte_valid), .byte_data(byte_data), .mf_start(mf_start),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    initial begin
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog (R1..R10 incomplete) actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] model_read(input logic [7:0] a);
        logic [7:0] v = 8'h00;
        if (a >= 8'h01 && a <= 8'h18) v = {4'h0, m_imm[a - 8'h01]};
        else if (a >= 8'h21 && a <= 8'h38) v = {4'h0, m_dly[a - 8'h21]};
        else if (a >= 8'h40 && a <= 8'h42)
            for (int i = 0; i < 8; i++) v[i] = m_flag[(a - 8'h40) * 8 + i];
        return v;
    endfunction

    function automatic string tag_of(input logic [7:0] a, input string t);
        if (a >= 8'h01 && a <= 8'h18) return {t, "/R4"};
        if (a >= 8'h21 && a <= 8'h38) return {t, "/R5"};
        if (a >= 8'h40 && a <= 8'h42) return {t, "/R6"};
        return {t, "/R10"};
    endfunction

    // One posedge of the model, written from the requirements.
    task automatic model_step(input logic v, input logic [7:0] d, input logic mf,
                              input logic rd, input logic [7:0] ra);
        bit mode_chg = (esf_mode != m_mode_q);
        bit take = v && (mf || (m_locked && !mode_chg));
        bit setf [24];
        for (int i = 0; i < 24; i++) setf[i] = 1'b0;
        if (take) begin
            int ch = mf ? 0 : m_ch;
            int fr = mf ? 0 : m_frm;
            int nfr = esf_mode ? 24 : 12;
            if (fr % 6 == 5) begin
                int slot = fr / 6;
                bit last = (slot == (esf_mode ? 3 : 1));
                if (last) begin
                    logic [3:0] a = m_acc[ch];
                    logic [3:0] code = esf_mode ? {a[3], a[2], a[1], d[0]}
                                                : {a[3], d[0], a[3], d[0]};
                    if (m_primed && code != m_imm[ch]) setf[ch] = 1'b1;
                    m_dly[ch] = m_imm[ch];
                    m_imm[ch] = code;
                    if (ch == 23) m_primed = 1'b1;
                end else begin
                    m_acc[ch][3 - slot] = d[0];
                end
            end
            if (ch == 23) begin m_ch = 0; m_frm = (fr == nfr - 1) ? 0 : fr + 1; end
            else begin m_ch = ch + 1; m_frm = fr; end
        end
        if (rd && ra >= 8'h40 && ra <= 8'h42)
            for (int i = 0; i < 8; i++) m_flag[(ra - 8'h40) * 8 + i] = 1'b0;
        for (int i = 0; i < 24; i++) if (setf[i]) m_flag[i] = 1'b1;
        if (take && mf) m_locked = 1'b1;
        else if (mode_chg) m_locked = 1'b0;
        m_mode_q = esf_mode;
    endtask

    task automatic tick(input logic v, input logic [7:0] d, input logic mf,
                        input logic rd, input logic [7:0] ra, input string t);
        logic [7:0] exp_rd;
        @(negedge clk);
        byte_valid = v; byte_data = d; mf_start = mf; rd_en = rd; rd_addr = ra;
        exp_rd = model_read(ra);
        @(posedge clk);
        model_step(v, d, mf, rd, ra);
        #2;
        if (rd) check(rd_data == exp_rd, tag_of(ra, t), rd_data, exp_rd);
    endtask

    function automatic logic [3:0] gen_code(input int seed, input int c);
        logic [3:0] base = 4'((c * 5 + 3) & 15);
        return (c % 3 == 0) ? (base ^ 4'(seed)) : base;
    endfunction

    // Send one multiframe (or its first max_bytes), optionally reading the
    // flag byte on the byte that completes channel rd_ch.
    task automatic send_mf(input int seed, input int max_bytes, input int rd_ch);
        int nfr = esf_mode ? 24 : 12;
        int n = 0;
        for (int f = 0; f < nfr; f++) begin
            for (int c = 0; c < 24; c++) begin
                logic [3:0] code = gen_code(seed, c);
                logic [7:0] d = 8'((c * 13 + f * 7) | 1);
                bit rd;
                if (n >= max_bytes) return;
                if (f % 6 == 5) d[0] = esf_mode ? code[3 - f / 6] : code[3 - f / 6];
                else d[0] = ~code[0];                  // ignored bits (R2)
                rd = (rd_ch >= 0 && f == nfr - 1 && c == rd_ch);
                tick(1'b1, d, (f == 0 && c == 0), rd, 8'(8'h40 + c / 8), "R7");
                n++;
                if (n % 7 == 0) tick(1'b0, 8'hFF, 1'b0, 1'b0, 8'h00, "R1");
            end
        end
    endtask

    task automatic check_all(input string t);
        for (int c = 0; c < 24; c++) tick(1'b0, 8'h00, 1'b0, 1'b1, 8'(8'h01 + c), t);
        for (int c = 0; c < 24; c++) tick(1'b0, 8'h00, 1'b0, 1'b1, 8'(8'h21 + c), t);
        for (int g = 0; g < 3; g++) tick(1'b0, 8'h00, 1'b0, 1'b1, 8'(8'h40 + g), t);
        for (int g = 0; g < 3; g++) tick(1'b0, 8'h00, 1'b0, 1'b1, 8'(8'h40 + g), {t, "/R7"});
    endtask

    initial begin
        logic [7:0] held;
        for (int i = 0; i < 24; i++) begin
            m_imm[i] = '0; m_dly[i] = '0; m_acc[i] = '0; m_flag[i] = 1'b0;
        end
        m_primed = 1'b0; m_locked = 1'b0; m_mode_q = 1'b1; m_ch = 0; m_frm = 0;
        repeat (4) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // Reset state (R8) and unmapped addresses (R10)
        tick(1'b0, 8'h00, 1'b0, 1'b1, 8'h05, "R8");
        tick(1'b0, 8'h00, 1'b0, 1'b1, 8'h25, "R8");
        tick(1'b0, 8'h00, 1'b0, 1'b1, 8'h41, "R8");
        foreach (held[i]) ;
        tick(1'b0, 8'h00, 1'b0, 1'b1, 8'h00, "R10");
        tick(1'b0, 8'h00, 1'b0, 1'b1, 8'h19, "R10");
        tick(1'b0, 8'h00, 1'b0, 1'b1, 8'h39, "R10");
        tick(1'b0, 8'h00, 1'b0, 1'b1, 8'hFF, "R10");

        // ESF priming multiframe: codes load, no flags (R8, R2, R1)
        send_mf(0, 100000, -1);
        check_all("R8/R2/R1");

        // ESF with changes on every third channel (R2, R5, R6)
        send_mf(1, 100000, -1);
        check_all("R2/R6");

        // Flag byte read on the very byte that completes changed channel 9 (R7)
        send_mf(2, 100000, 9);
        check_all("R7");

        // Hold while idle (R10)
        tick(1'b0, 8'h00, 1'b0, 1'b1, 8'h03, "R10");
        held = rd_data;
        tick(1'b0, 8'h00, 1'b0, 1'b0, 8'h21, "R10");
        check(rd_data == held, "R10 hold", rd_data, held);

        // Partial ESF, then a mode change with misaligned traffic (R9)
        send_mf(3, 100, -1);
        @(negedge clk); esf_mode = 1'b0;
        for (int i = 0; i < 240; i++)
            tick(1'b1, 8'(i * 3 | 1), 1'b0, 1'b0, 8'h00, "R9");
        check_all("R9");

        // SF multiframes: A and B repeated as C and D (R3)
        send_mf(4, 100000, -1);
        check_all("R3");
        send_mf(5, 100000, -1);
        check_all("R3/R5");

        // Back to ESF: relock on the next start marker (R9, R2)
        @(negedge clk); esf_mode = 1'b1;
        send_mf(6, 100000, -1);
        check_all("R9/R2");
        send_mf(7, 100000, -1);
        check_all("R2/R5");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule